// File: doc/BRIEF.md
# Strobe-Clocked I/O Register Slave

This block is a small register window for an ISA-style peripheral bus. The system clock driving the rest of the chip may sit anywhere between a few MHz and several tens of MHz. For that reason the block never samples the bus with that clock. The active-low read and write command strobes act as clocks themselves. A plain register write is taken on the trailing (rising) edge of the write strobe. Read data comes from a combinational multiplexer steered by the low address bits. The data-bus output enable is raised only while the read strobe is low and the address falls inside the window.

Some bus operations act on state that lives in the system clock domain. A write that sets status flags, a write that pushes a byte downstream, and a read of the status register that clears it each flip a toggle in the strobe domain. A synchroniser turns each toggle into exactly one system-clock pulse. The status register is read-to-clear. The clear lands a few system cycles after the read strobe ends. Any hardware event bits that are set in that same cycle survive the clear.

Top module: `strobe_bus_slave`

## Requirements
- R1: While reset is low, and after it is released, the control, scratch and status registers read zero, the bus drive enable is low and no push pulse is issued.
- R2: A write strobe whose rising edge falls at window offset 0 (control) or offset 1 (scratch) loads the write data into that register at that edge.
- R3: Bus cycles whose address has its upper bits (above bit 1) unequal to those of the base address change no register, issue no push and never raise the drive enable.
- R4: The drive enable is high exactly while the read strobe is low and the address lies in the four-register window.
- R5: While driving, the read data is control at offset 0, scratch at offset 1, status at offset 2, and the last pushed byte at offset 3. While not driving, the read data is zero.
- R6: Each write to offset 3 produces exactly one single-cycle push pulse in the system domain, carrying the written byte.
- R7: After a read strobe at offset 2 ends, the status register is cleared within a few system cycles.
- R8: A write to offset 2 ORs the written byte into the status register (write 1 to set), and leaves bits already set untouched.
- R9: Event bits presented on the system-domain set input are ORed into status every cycle, and they take priority over a read-to-clear landing in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the side-effect domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address lines |
| bus_wdata | input | DW | Data presented by the bus master on writes |
| ior_n | input | 1 | Active-low read command strobe |
| iow_n | input | 1 | Active-low write command strobe |
| evt_set | input | DW | System-domain status set bits |
| bus_rdata | output | DW | Read data toward the bus transceivers |
| bus_drive_en | output | 1 | Tri-state enable for the read data |
| ctrl_q | output | DW | Control register contents |
| scratch_q | output | DW | Scratch register contents |
| status_q | output | DW | Status register contents |
| push_valid | output | 1 | One-cycle push pulse in the system domain |
| push_data | output | DW | Byte carried with the push pulse |

## Verification
The checks assume that bus command strobes stay low for several system clock periods and never pulse twice within one period. They also assume that the address and write data are stable across the strobe's rising edge, and that back-to-back side-effect operations are spaced further apart than the synchroniser latency. The event-set input is taken to be quiet through reset and its release. The bench drives strobes of 40 ns against a 5 ns system period, holds address and data 10 ns on each side of the strobe, and waits a dozen system cycles after every side-effect operation. It raises event bits only long after reset.

// File: rtl/bus_slave_pkg.sv
package bus_slave_pkg;

  localparam int WIN_BITS = 2;

  typedef enum logic [WIN_BITS-1:0] {
    OFS_CTRL    = 2'd0,
    OFS_SCRATCH = 2'd1,
    OFS_STATUS  = 2'd2,
    OFS_PUSH    = 2'd3
  } reg_ofs_e;

  // index of each side-effect toggle in the synchroniser bank
  localparam int XSYNC_PUSH = 0;
  localparam int XSYNC_SET  = 1;
  localparam int XSYNC_CLR  = 2;
  localparam int XSYNC_N    = 3;

endpackage

// File: rtl/bsl_decode.sv
module bsl_decode
  import bus_slave_pkg::*;
#(
  parameter int                ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h300
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output reg_ofs_e          ofs
);

  localparam int TAG_W = ADDR_W - WIN_BITS;

  logic [TAG_W-1:0] base_tag;

  always_comb begin
    base_tag = BASE_ADDR[ADDR_W-1:WIN_BITS];
    hit      = (addr[ADDR_W-1:WIN_BITS] == base_tag);
    ofs      = reg_ofs_e'(addr[WIN_BITS-1:0]);
  end

endmodule

// File: rtl/bsl_strobe_regs.sv
module bsl_strobe_regs
  import bus_slave_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          iow_n,
  input  logic          rst_n,
  input  logic          hit,
  input  reg_ofs_e      ofs,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] scratch_q,
  output logic [DW-1:0] push_hold,
  output logic [DW-1:0] set_hold,
  output logic          push_tgl,
  output logic          set_tgl
);

  logic ctrl_en, scratch_en, push_en, set_en;
  logic push_tgl_d, set_tgl_d;

  always_comb begin
    ctrl_en    = hit && (ofs == OFS_CTRL);
    scratch_en = hit && (ofs == OFS_SCRATCH);
    set_en     = hit && (ofs == OFS_STATUS);
    push_en    = hit && (ofs == OFS_PUSH);
    push_tgl_d = push_tgl ^ push_en;
    set_tgl_d  = set_tgl ^ set_en;
  end

  // the trailing edge of the write strobe is the capture clock
  always_ff @(posedge iow_n or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      scratch_q <= '0;
      push_hold <= '0;
      set_hold  <= '0;
      push_tgl  <= 1'b0;
      set_tgl   <= 1'b0;
    end else begin
      if (ctrl_en)    ctrl_q    <= wdata;
      if (scratch_en) scratch_q <= wdata;
      if (push_en)    push_hold <= wdata;
      if (set_en)     set_hold  <= wdata;
      push_tgl <= push_tgl_d;
      set_tgl  <= set_tgl_d;
    end
  end

endmodule

// File: rtl/bsl_pulse_sync.sv
module bsl_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse
);

  logic [STAGES:0] chain_q, chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-1:0], tgl_in};
    pulse   = chain_q[STAGES] ^ chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

endmodule

// File: rtl/bsl_sys_regs.sv
module bsl_sys_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt_set,
  input  logic          set_pulse,
  input  logic [DW-1:0] set_hold,
  input  logic          clr_pulse,
  input  logic          push_pulse,
  input  logic [DW-1:0] push_hold,
  output logic [DW-1:0] status_q,
  output logic          push_valid,
  output logic [DW-1:0] push_data
);

  logic [DW-1:0] status_d, push_data_d;
  logic          push_valid_d;

  always_comb begin
    status_d = status_q;
    if (clr_pulse) status_d = '0;
    if (set_pulse) status_d = status_d | set_hold;
    status_d     = status_d | evt_set;   // events win over the clear
    push_valid_d = push_pulse;
    push_data_d  = push_pulse ? push_hold : push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q   <= '0;
      push_valid <= 1'b0;
      push_data  <= '0;
    end else begin
      status_q   <= status_d;
      push_valid <= push_valid_d;
      push_data  <= push_data_d;
    end
  end

endmodule

// File: rtl/strobe_bus_slave.sv
module strobe_bus_slave
  import bus_slave_pkg::*;
#(
  parameter int                ADDR_W      = 10,
  parameter int                DW          = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 10'h300,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              sys_clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              ior_n,
  input  logic              iow_n,
  input  logic [DW-1:0]     evt_set,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_drive_en,
  output logic [DW-1:0]     ctrl_q,
  output logic [DW-1:0]     scratch_q,
  output logic [DW-1:0]     status_q,
  output logic              push_valid,
  output logic [DW-1:0]     push_data
);

  logic          hit;
  reg_ofs_e      ofs;
  logic [DW-1:0] push_hold, set_hold, rd_mux;
  logic          clr_tgl, clr_tgl_d;
  logic [XSYNC_N-1:0] tgl_vec, pulse_vec;
  logic [1:0]    rst_pipe;
  logic          rst_sys_n;

  bsl_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr(bus_addr), .hit(hit), .ofs(ofs)
  );

  bsl_strobe_regs #(.DW(DW)) u_wr (
    .iow_n(iow_n), .rst_n(rst_n), .hit(hit), .ofs(ofs), .wdata(bus_wdata),
    .ctrl_q(ctrl_q), .scratch_q(scratch_q), .push_hold(push_hold),
    .set_hold(set_hold), .push_tgl(tgl_vec[XSYNC_PUSH]),
    .set_tgl(tgl_vec[XSYNC_SET])
  );

  // read side: the trailing read edge requests the status clear
  always_comb clr_tgl_d = clr_tgl ^ (hit && (ofs == OFS_STATUS));

  always_ff @(posedge ior_n or negedge rst_n) begin
    if (!rst_n) clr_tgl <= 1'b0;
    else        clr_tgl <= clr_tgl_d;
  end

  assign tgl_vec[XSYNC_CLR] = clr_tgl;

  always_comb begin
    unique case (ofs)
      OFS_CTRL:    rd_mux = ctrl_q;
      OFS_SCRATCH: rd_mux = scratch_q;
      OFS_STATUS:  rd_mux = status_q;
      OFS_PUSH:    rd_mux = push_hold;
      default:     rd_mux = '0;
    endcase
    bus_drive_en = rst_n && !ior_n && hit;
    bus_rdata    = bus_drive_en ? rd_mux : '0;
  end

  // reset asserts at once, releases on the system clock
  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sys_n = rst_pipe[1];

  for (genvar g = 0; g < XSYNC_N; g++) begin : g_xsync
    bsl_pulse_sync #(.STAGES(SYNC_STAGES)) u_ps (
      .clk(sys_clk), .rst_n(rst_sys_n), .tgl_in(tgl_vec[g]), .pulse(pulse_vec[g])
    );
  end

  bsl_sys_regs #(.DW(DW)) u_sys (
    .clk(sys_clk), .rst_n(rst_sys_n), .evt_set(evt_set),
    .set_pulse(pulse_vec[XSYNC_SET]), .set_hold(set_hold),
    .clr_pulse(pulse_vec[XSYNC_CLR]), .push_pulse(pulse_vec[XSYNC_PUSH]),
    .push_hold(push_hold), .status_q(status_q), .push_valid(push_valid),
    .push_data(push_data)
  );

endmodule

// File: rtl/strobe_bus_slave_chk.sv
module strobe_bus_slave_chk #(
  parameter int DW = 8
) (
  input logic          sys_clk,
  input logic          rst_n,
  input logic          ior_n,
  input logic          iow_n,
  input logic          bus_drive_en,
  input logic [DW-1:0] bus_rdata,
  input logic [DW-1:0] evt_set,
  input logic [DW-1:0] ctrl_q,
  input logic [DW-1:0] status_q,
  input logic          push_valid
);

  // R1
  always_comb begin
    if (!rst_n) reset_quiet_chk: assert (!bus_drive_en && ctrl_q == '0);
  end

  // R4
  drv_needs_read_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    bus_drive_en |-> !ior_n);

  // R5
  idle_bus_zero_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !bus_drive_en |-> (bus_rdata == '0));

  // R6
  single_push_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    push_valid |=> !push_valid);

  // R2
  ctrl_hold_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (!iow_n && $past(!iow_n)) |-> $stable(ctrl_q));

  // R9
  evt_set_wins_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (|evt_set) |=> ((status_q & $past(evt_set)) == $past(evt_set)));

endmodule

bind strobe_bus_slave strobe_bus_slave_chk #(.DW(DW)) u_chk (
  .sys_clk(sys_clk), .rst_n(rst_n), .ior_n(ior_n), .iow_n(iow_n),
  .bus_drive_en(bus_drive_en), .bus_rdata(bus_rdata), .evt_set(evt_set),
  .ctrl_q(ctrl_q), .status_q(status_q), .push_valid(push_valid)
);

// File: tb/tb_strobe_bus_slave.sv
`timescale 1ns/1ps
module tb_strobe_bus_slave;

  localparam int          ADDR_W = 10;
  localparam int          DW     = 8;
  localparam logic [9:0]  BASE   = 10'h300;

  logic              sys_clk = 1'b0;
  logic              rst_n   = 1'b0;
  logic [ADDR_W-1:0] bus_addr  = '0;
  logic [DW-1:0]     bus_wdata = '0;
  logic              ior_n = 1'b1, iow_n = 1'b1;
  logic [DW-1:0]     evt_set = '0;
  logic [DW-1:0]     bus_rdata, ctrl_q, scratch_q, status_q, push_data;
  logic              bus_drive_en, push_valid;

  int vecs = 0, miss = 0;
  int push_cnt = 0;
  logic [DW-1:0] push_last = '0;

  always #2.5 sys_clk = ~sys_clk;

  strobe_bus_slave #(.ADDR_W(ADDR_W), .DW(DW), .BASE_ADDR(BASE)) dut (
    .sys_clk(sys_clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .ior_n(ior_n), .iow_n(iow_n), .evt_set(evt_set), .bus_rdata(bus_rdata),
    .bus_drive_en(bus_drive_en), .ctrl_q(ctrl_q), .scratch_q(scratch_q),
    .status_q(status_q), .push_valid(push_valid), .push_data(push_data)
  );

  always @(negedge sys_clk) begin
    if (push_valid) begin
      push_cnt++;
      push_last = push_data;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d);
    bus_addr = a; bus_wdata = d;
    #10 iow_n = 1'b0;
    #40 iow_n = 1'b1;
    #10;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [DW-1:0] d, output logic en);
    bus_addr = a;
    #10 ior_n = 1'b0;
    #20 d = bus_rdata; en = bus_drive_en;
    #20 ior_n = 1'b1;
    #10;
  endtask

  task automatic settle();
    repeat (12) @(negedge sys_clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  endtask

  initial begin
    #900000;
    miss++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [DW-1:0] rd;
    logic          en;
    logic [DW-1:0] exp_ctrl, exp_scr, exp_stat;
    int            pc;

    // R1: reset state
    #3;
    check("R1 ctrl in reset", ctrl_q, 0);
    check("R1 drive_en in reset", bus_drive_en, 0);
    #20 rst_n = 1'b1;
    repeat (10) @(negedge sys_clk);
    check("R1 ctrl", ctrl_q, 0);
    check("R1 scratch", scratch_q, 0);
    check("R1 status", status_q, 0);
    check("R1 drive_en", bus_drive_en, 0);
    check("R1 push count", push_cnt, 0);

    // R2: full data sweep over both plain registers
    for (int d = 0; d < 256; d++) begin
      bus_wr(BASE + 10'd0, DW'(d));
      check("R2 ctrl load", ctrl_q, d);
      bus_wr(BASE + 10'd1, DW'(255 - d));
      check("R2 scratch load", scratch_q, 255 - d);
    end
    exp_ctrl = 8'hFF; exp_scr = 8'h00;

    // R3: cycles outside the window have no effect
    pc = push_cnt;
    for (int i = -8; i < 12; i++) begin
      logic [ADDR_W-1:0] a;
      a = ADDR_W'(int'(BASE) + i);
      if (i >= 0 && i < 4) continue;
      bus_wr(a, 8'h5A);
      check("R3 ctrl untouched", ctrl_q, exp_ctrl);
      check("R3 scratch untouched", scratch_q, exp_scr);
      bus_rd(a, rd, en);
      check("R3 no drive", en, 0);
      check("R3 rdata zero", rd, 0);
    end
    settle();
    check("R3 no push", push_cnt, pc);
    check("R3 status untouched", status_q, 0);

    // R6: push sweep
    for (int v = 0; v < 32; v++) begin
      logic [DW-1:0] pv;
      pv = DW'(v * 7 + 3);
      pc = push_cnt;
      bus_wr(BASE + 10'd3, pv);
      settle();
      check("R6 one push", push_cnt, pc + 1);
      check("R6 push data", push_last, pv);
    end

    // R8: write-one-to-set accumulates
    bus_wr(BASE + 10'd2, 8'h11); settle();
    bus_wr(BASE + 10'd2, 8'h20); settle();
    exp_stat = 8'h31;
    check("R8 status set", status_q, exp_stat);

    // R4/R5: read mux at every offset
    bus_wr(BASE + 10'd0, 8'h3C);
    bus_wr(BASE + 10'd1, 8'hC3);
    bus_wr(BASE + 10'd3, 8'h7E); settle();
    check("R6 push 7E", push_last, 8'h7E);
    bus_rd(BASE + 10'd0, rd, en);
    check("R4 drive at ofs0", en, 1);
    check("R5 ctrl readback", rd, 8'h3C);
    bus_rd(BASE + 10'd1, rd, en);
    check("R5 scratch readback", rd, 8'hC3);
    bus_rd(BASE + 10'd3, rd, en);
    check("R5 pushed readback", rd, 8'h7E);
    check("R4 drive off after strobe", bus_drive_en, 0);
    check("R5 idle rdata", bus_rdata, 0);
    bus_rd(BASE + 10'd2, rd, en);
    check("R5 status readback", rd, exp_stat);
    settle();
    // R7: read-to-clear
    check("R7 status cleared", status_q, 0);
    bus_rd(BASE + 10'd2, rd, en);
    check("R7 reread zero", rd, 0);
    settle();

    // R9: held event bit survives a clear
    @(negedge sys_clk) evt_set = 8'h04;
    bus_wr(BASE + 10'd2, 8'h80); settle();
    check("R9 evt plus set", status_q, 8'h84);
    bus_rd(BASE + 10'd2, rd, en); settle();
    check("R9 event beats clear", status_q, 8'h04);
    @(negedge sys_clk) evt_set = 8'h00;
    bus_rd(BASE + 10'd2, rd, en); settle();
    check("R7 clear after release", status_q, 0);
    @(negedge sys_clk) evt_set = 8'h10;
    @(negedge sys_clk) evt_set = 8'h00;
    settle();
    check("R9 single event pulse", status_q, 8'h10);
    check("R2 ctrl kept", ctrl_q, 8'h3C);

    finish_run();
  end

endmodule